// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a 16 KB on-chip scratchpad built from sixteen single-ported banks, each one 32-bit word wide. A request carries sixteen lanes, one per thread of a half-group. Each lane has a word address, write data, a write enable and a valid bit. The block works out which bank each lane targets and finds lanes that collide on a bank. It then serves the request over as many passes as the worst collision needs, and finally returns one 32-bit result per lane.

A bank is chosen by the low bits of the word address, so the time an access takes depends on its address stride. In each pass, every bank first serves its lowest-numbered waiting lane. The same pass also serves every other waiting lane that wants that same word. Reads of one word by several lanes are therefore a broadcast and cost nothing extra. The request side stays blocked from acceptance until the response has been taken.

Top module: `smem_bank_arbiter`

## Requirements
- R1: A lane's 12-bit word address selects bank = addr[3:0] and row = addr[11:4]. All 4096 words are stored independently, and a read returns the last value written to that word.
- R2: Lanes that all hit different banks (stride-1 or any one-to-one bank permutation) complete in a single pass.
- R3: The pass count P equals the largest number of distinct words requested in any one bank. Stride 2 gives P=2, stride 8 gives P=8, and sixteen distinct words in one bank give P=16.
- R4: Lanes that read the same word are all served in the same pass and all receive its value. Such sharing adds no pass.
- R5: After reset, req_ready=1 and resp_valid=0. req_ready falls at the edge that accepts a request and stays low until the response is taken. resp_valid rises exactly P clock edges after the accepting edge, with P=0 for an all-zero valid mask.
- R6: While resp_valid=1 and resp_ready=0, resp_valid stays high and resp_data does not change.
- R7: When several valid lanes write one word in the same request, the word keeps the data of the highest-numbered of those lanes.
- R8: A lane reading a word that another lane of the same request writes returns the value the word held before the request.
- R9: A lane whose valid bit is 0 writes nothing, and its resp_data field is 0. The resp_data field of a valid writing lane is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_mask | input | 16 | Per-lane valid bit, bit i for lane i |
| req_we | input | 16 | Per-lane write enable, bit i for lane i |
| req_addr | input | 192 | Lane i word address in bits [12i+11:12i] |
| req_wdata | input | 512 | Lane i write data in bits [32i+31:32i] |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Response taken |
| resp_data | output | 512 | Lane i read result in bits [32i+31:32i] |

## Verification
Some properties are checked on every cycle while passes run:
- each bank serves its lowest waiting lane;
- lanes served together in one bank share a row;
- the set of waiting lanes shrinks on every pass and never gains a lane it did not have;
- the response is held stable while it is stalled.

Other behaviour can only be shown by the bench's scenarios, which compare results against a reference model:
- the exact pass count for each address pattern;
- which writer wins;
- read-before-write within one request;
- that masked lanes leave storage alone.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } state_e;

endpackage

// File: rtl/smem_bank.sv
module smem_bank #(
    parameter int ROWS   = 256,
    parameter int DATA_W = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [ROWS];

    // single port: one row per cycle, read sees the value before this edge's write
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem_q[row] <= wdata;
        end
    end

    assign rdata = mem_q[row];

endmodule

// File: rtl/smem_pass_select.sv
module smem_pass_select #(
    parameter int LANES  = 16,
    parameter int NBANKS = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]         pending,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES*ADDR_W-1:0]  lane_addr,
    input  logic [LANES*DATA_W-1:0]  lane_wdata,
    output logic [LANES-1:0]         served,
    output logic [NBANKS-1:0]        bank_act,
    output logic [NBANKS*ROW_W-1:0]  bank_row,
    output logic [NBANKS-1:0]        bank_wr,
    output logic [NBANKS*DATA_W-1:0] bank_wdata
);

    logic [BANK_W-1:0] lane_bank [LANES];
    logic [ROW_W-1:0]  lane_row  [LANES];
    logic [LANES-1:0]  grp_all   [NBANKS];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_bank[l] = lane_addr[l*ADDR_W +: BANK_W];
        assign lane_row[l]  = lane_addr[l*ADDR_W+BANK_W +: ROW_W];
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic              found;
        logic [ROW_W-1:0]  row_sel;
        logic [LANES-1:0]  group;
        logic              wr;
        logic [DATA_W-1:0] wd;

        always_comb begin
            found   = 1'b0;
            row_sel = '0;
            // the lowest waiting lane of this bank picks the row for the pass
            for (int l = 0; l < LANES; l++) begin
                if (!found && pending[l] && lane_bank[l] == BANK_W'(b)) begin
                    found   = 1'b1;
                    row_sel = lane_row[l];
                end
            end
            group = '0;
            wr    = 1'b0;
            wd    = '0;
            // every waiting lane on that row rides along; ascending scan lets the top writer win
            for (int l = 0; l < LANES; l++) begin
                if (pending[l] && lane_bank[l] == BANK_W'(b) && lane_row[l] == row_sel) begin
                    group[l] = 1'b1;
                    if (lane_we[l]) begin
                        wr = 1'b1;
                        wd = lane_wdata[l*DATA_W +: DATA_W];
                    end
                end
            end
        end

        assign grp_all[b]                       = group;
        assign bank_act[b]                      = found;
        assign bank_row[b*ROW_W +: ROW_W]       = row_sel;
        assign bank_wr[b]                       = wr;
        assign bank_wdata[b*DATA_W +: DATA_W]   = wd;
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < NBANKS; b++) begin
            served = served | grp_all[b];
        end
    end

endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
    import smem_arb_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int NBANKS = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4096,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES-1:0]        req_we,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES*DATA_W-1:0] req_wdata,
    output logic                    resp_valid,
    input  logic                    resp_ready,
    output logic [LANES*DATA_W-1:0] resp_data
);

    localparam int BANK_W = $clog2(NBANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = WORDS / NBANKS;

    typedef struct packed {
        state_e                  state;
        logic [LANES-1:0]        pending;
        logic [LANES-1:0]        we;
        logic [LANES*ADDR_W-1:0] addr;
        logic [LANES*DATA_W-1:0] wdata;
        logic [LANES*DATA_W-1:0] rdata;
    } arb_st_t;

    arb_st_t st_q, st_d;

    logic                     run;
    logic [LANES-1:0]         served;
    logic [NBANKS-1:0]        bank_act;
    logic [NBANKS*ROW_W-1:0]  bank_row;
    logic [NBANKS-1:0]        bank_wr;
    logic [NBANKS*DATA_W-1:0] bank_wdata;
    logic [NBANKS*DATA_W-1:0] bank_rdata;

    assign run = (st_q.state == ST_RUN);

    smem_pass_select #(
        .LANES (LANES),
        .NBANKS(NBANKS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_select (
        .pending   (st_q.pending & {LANES{run}}),
        .lane_we   (st_q.we),
        .lane_addr (st_q.addr),
        .lane_wdata(st_q.wdata),
        .served    (served),
        .bank_act  (bank_act),
        .bank_row  (bank_row),
        .bank_wr   (bank_wr),
        .bank_wdata(bank_wdata)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_store
        smem_bank #(
            .ROWS  (ROWS),
            .DATA_W(DATA_W)
        ) u_bank (
            .clk  (clk),
            .en   (bank_act[b] & run),
            .we   (bank_wr[b] & run),
            .row  (bank_row[b*ROW_W +: ROW_W]),
            .wdata(bank_wdata[b*DATA_W +: DATA_W]),
            .rdata(bank_rdata[b*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.pending = req_mask;
                    st_d.we      = req_we & req_mask;
                    st_d.addr    = req_addr;
                    st_d.wdata   = req_wdata;
                    st_d.rdata   = '0;
                    st_d.state   = (req_mask != '0) ? ST_RUN : ST_RESP;
                end
            end
            ST_RUN: begin
                st_d.pending = st_q.pending & ~served;
                for (int l = 0; l < LANES; l++) begin
                    if (served[l] && !st_q.we[l]) begin
                        st_d.rdata[l*DATA_W +: DATA_W] =
                            bank_rdata[int'(st_q.addr[l*ADDR_W +: BANK_W])*DATA_W +: DATA_W];
                    end
                end
                if (st_d.pending == '0) begin
                    st_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (resp_ready) begin
                    st_d.state = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.state == ST_IDLE);
    assign resp_valid = (st_q.state == ST_RESP);
    assign resp_data  = st_q.rdata;

    // ---------------- assertions ----------------

    logic [LANES-1:0] lowest_pend;
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lowest_pend[l] = st_q.pending[l];
            for (int m = 0; m < l; m++) begin
                if (st_q.pending[m] &&
                    st_q.addr[m*ADDR_W +: BANK_W] == st_q.addr[l*ADDR_W +: BANK_W]) begin
                    lowest_pend[l] = 1'b0;
                end
            end
        end
    end

    p_lowest_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((lowest_pend & ~served) == '0));

    p_served_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((served & ~st_q.pending) == '0));

    p_pass_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($countones(st_q.pending) < $countones($past(st_q.pending))));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        p_shared_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (run && served[l]) |->
                (bank_row[int'(st_q.addr[l*ADDR_W +: BANK_W])*ROW_W +: ROW_W]
                 == st_q.addr[l*ADDR_W+BANK_W +: ROW_W]));
    end

    p_accept_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_resp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

endmodule

// File: tb/smem_bank_arbiter_bench.sv
`timescale 1ns/1ps
module smem_bank_arbiter_bench;

    localparam int L  = 16;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NW = 4096;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_ready;
    logic [L-1:0]    req_mask;
    logic [L-1:0]    req_we;
    logic [L*AW-1:0] req_addr;
    logic [L*DW-1:0] req_wdata;
    logic            resp_valid;
    logic            resp_ready;
    logic [L*DW-1:0] resp_data;

    always #2 clk = ~clk;

    smem_bank_arbiter u_smem_bank_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_mask  (req_mask),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .resp_valid(resp_valid),
        .resp_ready(resp_ready),
        .resp_data (resp_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] model [NW];
    logic [AW-1:0] ta [L];
    logic [DW-1:0] tw [L];
    logic [L-1:0]  tmask, twe;
    string         lat_req = "R3";
    string         dat_req = "R1";

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_passes();
        int worst = 0;
        for (int b = 0; b < 16; b++) begin
            int cnt = 0;
            for (int l = 0; l < L; l++) begin
                bit dup = 1'b0;
                if (tmask[l] && ta[l][3:0] == b[3:0]) begin
                    for (int m = 0; m < l; m++) begin
                        if (tmask[m] && ta[m] == ta[l]) dup = 1'b1;
                    end
                    if (!dup) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        return worst;
    endfunction

    task automatic run_req();
        logic [DW-1:0] exp_d [L];
        logic [DW-1:0] snap;
        logic [L*DW-1:0] held;
        int exp_p, k, bad_lane, hold;
        bit ready_bad;
        exp_p = ref_passes();
        for (int l = 0; l < L; l++) begin
            exp_d[l] = (tmask[l] && !twe[l]) ? model[ta[l]] : '0;
        end
        for (int l = 0; l < L; l++) begin
            if (tmask[l] && twe[l]) model[ta[l]] = tw[l];
        end
        @(negedge clk);
        check(req_ready === 1'b1, "R5", "ready before request", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1;
        req_mask  = tmask;
        req_we    = twe;
        for (int l = 0; l < L; l++) begin
            req_addr[l*AW +: AW]  = ta[l];
            req_wdata[l*DW +: DW] = tw[l];
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        ready_bad = 1'b0;
        while (!resp_valid && k < 100) begin
            if (req_ready) ready_bad = 1'b1;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        if (req_ready) ready_bad = 1'b1;
        check(k == exp_p, lat_req, "pass count", 64'(k), 64'(exp_p));
        check(!ready_bad, "R5", "ready low while busy", {63'd0, ready_bad}, 64'd0);
        bad_lane = -1;
        for (int l = 0; l < L; l++) begin
            if (bad_lane < 0 && resp_data[l*DW +: DW] !== exp_d[l]) bad_lane = l;
        end
        if (bad_lane >= 0) begin
            snap = resp_data[bad_lane*DW +: DW];
            check(1'b0, dat_req, $sformatf("lane %0d data", bad_lane), 64'(snap), 64'(exp_d[bad_lane]));
        end else begin
            check(1'b1, dat_req, "lane data", 64'd0, 64'd0);
        end
        held = resp_data;
        hold = 1 + int'($urandom % 2);
        repeat (hold) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(resp_valid === 1'b1 && resp_data === held, "R6", "stalled response held",
              {63'd0, resp_valid}, 64'd1);
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resp_ready = 1'b0;
        check(req_ready === 1'b1 && resp_valid === 1'b0, "R5", "idle after response taken",
              {62'd0, req_ready, resp_valid}, 64'd2);
    endtask

    task automatic clear_req();
        tmask = '1;
        twe   = '0;
        for (int l = 0; l < L; l++) begin
            ta[l] = '0;
            tw[l] = '0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n      = 1'b0;
        req_valid  = 1'b0;
        resp_ready = 1'b0;
        req_mask   = '0;
        req_we     = '0;
        req_addr   = '0;
        req_wdata  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R5", "reset ready", {63'd0, req_ready}, 64'd1);
        check(resp_valid === 1'b0, "R5", "reset resp_valid", {63'd0, resp_valid}, 64'd0);

        // R1/R2: fill every word with stride-1 writes
        lat_req = "R2"; dat_req = "R9";
        for (int k = 0; k < NW / L; k++) begin
            clear_req();
            twe = '1;
            for (int l = 0; l < L; l++) begin
                ta[l] = AW'(k * L + l);
                tw[l] = $urandom;
            end
            run_req();
        end

        // R1/R2: read back through one-to-one bank permutations
        lat_req = "R2"; dat_req = "R1";
        for (int k = 0; k < NW / L; k++) begin
            clear_req();
            for (int l = 0; l < L; l++) ta[l] = AW'(k * L + ((l * 5 + k) % L));
            run_req();
        end

        // R3: stride 2, stride 8, sixteen words in one bank
        lat_req = "R3"; dat_req = "R1";
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(64 + 2 * l);
        run_req();
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(8 * l);
        run_req();
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(16 * l + 5);
        run_req();

        // R4: broadcast of one word, then two shared words in one bank
        lat_req = "R4"; dat_req = "R4";
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(37);
        run_req();
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = (l % 2 == 0) ? AW'(100) : AW'(116);
        run_req();

        // R7: every lane writes one word, then read it back
        lat_req = "R3"; dat_req = "R9";
        clear_req();
        twe = '1;
        for (int l = 0; l < L; l++) begin
            ta[l] = AW'(200);
            tw[l] = 32'hA000_0000 + 32'(l);
        end
        run_req();
        dat_req = "R7";
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(200);
        run_req();

        // R8: readers and writers of one word in the same request
        dat_req = "R8";
        clear_req();
        twe = 16'hFF00;
        for (int l = 0; l < L; l++) begin
            ta[l] = AW'(300);
            tw[l] = 32'hB000_0000 + 32'(l);
        end
        run_req();
        dat_req = "R7";
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(300);
        run_req();

        // R5: empty mask answers with zero passes
        lat_req = "R5"; dat_req = "R9";
        clear_req();
        tmask = '0;
        run_req();

        // R9: masked-off writers leave storage alone, masked readers return 0
        lat_req = "R3"; dat_req = "R9";
        clear_req();
        tmask = 16'h00FF;
        twe   = '1;
        for (int l = 0; l < L; l++) begin
            ta[l] = AW'(400 + l);
            tw[l] = 32'hC000_0000 + 32'(l);
        end
        run_req();
        clear_req();
        for (int l = 0; l < L; l++) ta[l] = AW'(400 + l);
        run_req();
        clear_req();
        tmask = 16'h5A5A;
        for (int l = 0; l < L; l++) ta[l] = AW'(400 + l);
        run_req();

        // random mix with dense conflicts
        lat_req = "R3"; dat_req = "R8";
        for (int n = 0; n < 400; n++) begin
            int base;
            base = int'($urandom % 60) * 64;
            tmask = 16'($urandom);
            twe   = 16'($urandom) & 16'($urandom);
            for (int l = 0; l < L; l++) begin
                ta[l] = AW'(base + int'($urandom % 64));
                tw[l] = $urandom;
            end
            run_req();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule